// File: doc/BRIEF.md
# 8-bit Arithmetic Unit with Half-Carry and Decimal Correction

This block is the byte-wide arithmetic and logic datapath of a small accumulator CPU. It has no decimal mode. Instead, it keeps a half-carry flag and offers two explicit correction operations that turn a binary sum or difference of packed BCD values into a valid BCD byte. Each operation takes two 8-bit operands, a 4-bit operation code and the incoming status flags. It produces an 8-bit result, a full set of next flag values, a mask that shows which flags the operation writes, and a strobe that shows whether the result is meant to be stored.

The arithmetic is combinational. A single register stage captures the result, the flags, the mask and the strobe on the clock edge where `in_valid` is high. The sequencer can then commit the masked flags into its status register. Operand `a` is the accumulator side. Single-operand operations use only `a`.

Top module: `alu8_flags`

## Requirements
- R1: Outputs are registered. One clock after a cycle with `in_valid`=1, `out_valid` is 1 and the other outputs show that operation's values. After a cycle with `in_valid`=0, `out_valid` is 0 and the other outputs hold their values. After reset, all outputs are 0.
- R2: The flag vectors are ordered {N,V,H,Z,C}, with N at bit 4 and C at bit 0. Op 0 (add) gives result = a+b+C. It writes all five flags and sets `res_we`. C is the carry out of bit 7. H is the carry from bit 3 into bit 4. V is set when a and b have the same sign and the result's sign differs from it.
- R3: Op 1 (subtract) gives result = a+~b+C, so C=1 means no borrow. It writes all five flags and sets `res_we`. H is the carry out of bit 3 of that sum, which is the inverted nibble borrow. V uses the sign rule of R2 with ~b in place of b.
- R4: Op 2 (compare) forms a+~b+1 and ignores the incoming C. It writes only N, Z and C (mask 5'b10011) and leaves `res_we` at 0.
- R5: Op 3 (AND), op 4 (OR), op 5 (XOR), op 6 (a+1) and op 7 (a-1) write only N and Z (mask 5'b10010) and set `res_we`.
- R6: Op 8 shifts a left, filling with 0. Op 9 shifts a right, filling with 0. Op 10 rotates a left through C. Op 11 rotates a right through C. Each of these writes N, Z and C, and C takes the bit shifted out.
- R7: Op 12 swaps a[7:4] with a[3:0]. It writes N and Z from the swapped byte.
- R8: Op 13 (correct after add) adds 0x60 and sets C when C=1 or a>0x99. It then adds 0x06 when H=1 or a[3:0]>9. Otherwise C keeps its input value. It writes N, Z and C.
- R9: Op 14 (correct after subtract) subtracts 0x60 and clears C when C=0 or a>0x99. It then subtracts 0x06 when H=0 or a[3:0]>9. Otherwise C keeps its input value. It writes N, Z and C.
- R10: Op 15 clears V and H (mask 5'b01100), changes no other flag and leaves `res_we` at 0.
- R11: A flag that is not in the mask equals its value in `flags_in`. A written N equals result bit 7, and a written Z is 1 exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| a | input | 8 | Accumulator-side operand |
| b | input | 8 | Second operand |
| flags_in | input | 5 | Incoming {N,V,H,Z,C} |
| out_valid | output | 1 | Registered outputs updated last edge |
| result | output | 8 | Result byte |
| flags_out | output | 5 | Next {N,V,H,Z,C} |
| flags_wr | output | 5 | Flags written by the operation |
| res_we | output | 1 | Result is to be stored |

## Verification
The hardest cases to reach are the two decimal corrections. In each of them, both the high and the low fix-up apply and the final byte wraps to zero. The after-add case needs a preceding binary add whose sum exceeds 0x99 while the nibble sum stays below 16. The stimulus chains real BCD additions and subtractions and feeds each produced C and H back into the correction step. Cases 45+55 and 10-01 drive the wrap and the borrow paths. The corrections are also driven with forced flag combinations that no real add could produce.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [3:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [4:0] flags_in,
  output logic       out_valid,
  output logic [7:0] result,
  output logic [4:0] flags_out,
  output logic [4:0] flags_wr,
  output logic       res_we
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,  OP_AND = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_INC = 4'd6,  OP_DEC = 4'd7;
  localparam logic [3:0] OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11;
  localparam logic [3:0] OP_SWP = 4'd12, OP_DAA = 4'd13, OP_DAS = 4'd14, OP_CLV = 4'd15;
  localparam logic [4:0] M_ALL = 5'b11111, M_NZC = 5'b10011, M_NZ = 5'b10010, M_VH = 5'b01100;

  logic       fc, fh;
  logic [7:0] bx;
  logic       cin;
  logic [8:0] sum;
  logic [4:0] lsum;
  logic       hi_a, lo_a, hi_s, lo_s, big;
  logic [7:0] r;
  logic       c_n, v_n, h_n, we_n;
  logic [4:0] m;
  logic [4:0] f_n;

  assign fc   = flags_in[0];
  assign fh   = flags_in[2];
  assign bx   = (op == OP_SUB || op == OP_CMP) ? ~b : b;
  assign cin  = (op == OP_CMP) ? 1'b1 : fc;
  assign sum  = {1'b0, a} + {1'b0, bx} + {8'd0, cin};
  assign lsum = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'd0, cin};
  assign big  = a > 8'h99;
  assign hi_a = fc | big;
  assign lo_a = fh | (a[3:0] > 4'd9);
  assign hi_s = ~fc | big;
  assign lo_s = ~fh | (a[3:0] > 4'd9);

  always_comb begin
    r    = a;
    c_n  = fc;
    v_n  = flags_in[3];
    h_n  = fh;
    m    = M_NZ;
    we_n = 1'b1;
    unique case (op)
      OP_ADD, OP_SUB: begin
        r   = sum[7:0];
        c_n = sum[8];
        h_n = lsum[4];
        v_n = (a[7] == bx[7]) && (sum[7] != a[7]);
        m   = M_ALL;
      end
      OP_CMP: begin
        r    = sum[7:0];
        c_n  = sum[8];
        m    = M_NZC;
        we_n = 1'b0;
      end
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_INC: r = a + 8'd1;
      OP_DEC: r = a - 8'd1;
      OP_SHL: begin r = {a[6:0], 1'b0}; c_n = a[7]; m = M_NZC; end
      OP_SHR: begin r = {1'b0, a[7:1]}; c_n = a[0]; m = M_NZC; end
      OP_ROL: begin r = {a[6:0], fc};   c_n = a[7]; m = M_NZC; end
      OP_ROR: begin r = {fc, a[7:1]};   c_n = a[0]; m = M_NZC; end
      OP_SWP: r = {a[3:0], a[7:4]};
      OP_DAA: begin
        r   = a + (hi_a ? 8'h60 : 8'h00) + (lo_a ? 8'h06 : 8'h00);
        c_n = hi_a;
        m   = M_NZC;
      end
      OP_DAS: begin
        r   = a - (hi_s ? 8'h60 : 8'h00) - (lo_s ? 8'h06 : 8'h00);
        c_n = ~hi_s;
        m   = M_NZC;
      end
      OP_CLV: begin
        v_n  = 1'b0;
        h_n  = 1'b0;
        m    = M_VH;
        we_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign f_n = {m[4] ? r[7] : flags_in[4],
                m[3] ? v_n  : flags_in[3],
                m[2] ? h_n  : flags_in[2],
                m[1] ? (r == 8'd0) : flags_in[1],
                m[0] ? c_n  : flags_in[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      flags_wr  <= '0;
      res_we    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= r;
        flags_out <= f_n;
        flags_wr  <= m;
        res_we    <= we_n;
      end
    end
  end
endmodule

module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [3:0] op,
  input logic [4:0] flags_in,
  input logic       out_valid,
  input logic [7:0] result,
  input logic [4:0] flags_out,
  input logic [4:0] flags_wr,
  input logic       res_we
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flags_out)); // R1
  AST_CMP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd2 |=> !res_we && flags_wr == 5'b10011); // R4
  AST_LOGIC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op >= 4'd3 && op <= 4'd7 |=> res_we && flags_wr == 5'b10010); // R5
  AST_CLRV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd15 |=> flags_out[3:2] == 2'b00 && !res_we); // R10
  AST_UNMASKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((flags_out ^ $past(flags_in)) & ~flags_wr) == 5'd0); // R11
  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_we && flags_wr[4] |-> flags_out[4] == result[7] && flags_out[1] == (result == 8'd0)); // R11
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .flags_in(flags_in),
  .out_valid(out_valid), .result(result), .flags_out(flags_out),
  .flags_wr(flags_wr), .res_we(res_we)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [4:0] flags_in = '0;
  logic       out_valid, res_we;
  logic [7:0] result;
  logic [4:0] flags_out, flags_wr;

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] r;
    logic [4:0] f;
    logic [4:0] m;
    logic       we;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t last;

  alu8_flags u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .flags_out(flags_out), .flags_wr(flags_wr), .res_we(res_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                                 input logic [4:0] f, input string tag);
    exp_t e;
    int s, lo, xb, ci, d;
    logic c, v, h;
    c = f[0]; v = f[3]; h = f[2];
    e.we = 1; e.m = 5'b10010; e.r = x; e.tag = tag;
    case (o)
      0, 1, 2: begin
        xb = (o == 0) ? y : (~y & 8'hFF);
        ci = (o == 2) ? 1 : f[0];
        s = x + xb + ci;
        lo = (x & 15) + (xb & 15) + ci;
        e.r = s[7:0];
        c = s > 255;
        if (o != 2) begin
          h = lo > 15;
          v = (x[7] == xb[7]) && (e.r[7] != x[7]);
          e.m = 5'b11111;
        end else begin
          e.m = 5'b10011; e.we = 0;
        end
      end
      3: e.r = x & y;
      4: e.r = x | y;
      5: e.r = x ^ y;
      6: e.r = x + 8'd1;
      7: e.r = x - 8'd1;
      8:  begin e.r = x << 1; c = x[7]; e.m = 5'b10011; end
      9:  begin e.r = x >> 1; c = x[0]; e.m = 5'b10011; end
      10: begin e.r = {x[6:0], f[0]}; c = x[7]; e.m = 5'b10011; end
      11: begin e.r = {f[0], x[7:1]}; c = x[0]; e.m = 5'b10011; end
      12: e.r = {x[3:0], x[7:4]};
      13: begin
        d = x;
        if (f[0] || x > 8'h99) begin d = d + 'h60; c = 1; end
        if (f[2] || (d & 15) > 9) d = d + 6;
        e.r = d[7:0]; e.m = 5'b10011;
      end
      14: begin
        d = x;
        if (!f[0] || x > 8'h99) begin d = d - 'h60; c = 0; end
        if (!f[2] || (d & 15) > 9) d = d - 6;
        e.r = d[7:0]; e.m = 5'b10011;
      end
      default: begin v = 0; h = 0; e.m = 5'b01100; e.we = 0; end
    endcase
    e.f = f;
    if (e.m[4]) e.f[4] = e.r[7];
    if (e.m[3]) e.f[3] = v;
    if (e.m[2]) e.f[2] = h;
    if (e.m[1]) e.f[1] = (e.r == 0);
    if (e.m[0]) e.f[0] = c;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic [4:0] f, input string tag);
    @(negedge clk);
    op = o; a = x; b = y; flags_in = f; in_valid = 1'b1;
    q.push_back(model(o, x, y, f, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (q.size() == 0) check(0, "R1", "unexpected out_valid", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        last = e;
        if (e.we) check(result == e.r, e.tag, "result", result, e.r);
        check(flags_out == e.f, e.tag, "flags", flags_out, e.f);
        check(flags_wr == e.m, e.tag, "mask", flags_wr, e.m);
        check(res_we == e.we, e.tag, "res_we", res_we, e.we);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && result == 0 && flags_out == 0 && flags_wr == 0 && res_we == 0,
          "R1", "reset state", {out_valid, result, flags_out}, 0);
    rst_n = 1'b1;
    // R2 add
    drive(0, 8'h3A, 8'h48, 5'b00000, "R2");
    drive(0, 8'hFF, 8'h01, 5'b00000, "R2");
    drive(0, 8'h80, 8'h80, 5'b00001, "R2");
    drive(0, 8'h0F, 8'h00, 5'b00001, "R2");
    // R3 subtract
    drive(1, 8'h50, 8'h30, 5'b00001, "R3");
    drive(1, 8'h10, 8'h01, 5'b00001, "R3");
    drive(1, 8'h00, 8'h01, 5'b00001, "R3");
    drive(1, 8'h80, 8'h01, 5'b00000, "R3");
    // R4 compare ignores C and V/H
    drive(2, 8'h40, 8'h40, 5'b01100, "R4");
    drive(2, 8'h10, 8'h20, 5'b00001, "R4");
    // R5 logic and inc/dec
    drive(3, 8'hF0, 8'h3C, 5'b01101, "R5");
    drive(4, 8'h00, 8'h00, 5'b01001, "R5");
    drive(5, 8'hAA, 8'h55, 5'b00000, "R5");
    drive(6, 8'hFF, 8'h00, 5'b10001, "R5");
    drive(7, 8'h00, 8'h00, 5'b00010, "R5");
    // R6 shifts and rotates
    drive(8, 8'h81, 8'h00, 5'b00000, "R6");
    drive(9, 8'h01, 8'h00, 5'b00000, "R6");
    drive(10, 8'h40, 8'h00, 5'b00001, "R6");
    drive(11, 8'h02, 8'h00, 5'b00001, "R6");
    // R7 nibble swap
    drive(12, 8'h8C, 8'h00, 5'b01111, "R7");
    drive(12, 8'h00, 8'h00, 5'b10000, "R7");
    // R8 correction after add: 45+55 -> 0x9A then 0x00 with carry
    drive(0, 8'h45, 8'h55, 5'b00000, "R2");
    drive(13, 8'h9A, 8'h00, 5'b00000, "R8");
    drive(13, 8'h19, 8'h00, 5'b00100, "R8");
    drive(13, 8'h12, 8'h00, 5'b00001, "R8");
    drive(13, 8'h42, 8'h00, 5'b00000, "R8");
    // R9 correction after subtract: 10-01 -> 0x0F
    drive(1, 8'h10, 8'h01, 5'b00001, "R3");
    drive(14, 8'h0F, 8'h00, 5'b00001, "R9");
    drive(14, 8'hF9, 8'h00, 5'b00100, "R9");
    drive(14, 8'h37, 8'h00, 5'b00101, "R9");
    // R10 clear V/H
    drive(15, 8'h12, 8'h34, 5'b11111, "R10");
    drive(15, 8'h00, 8'h00, 5'b01000, "R10");
    // R11 pass-through of unwritten flags
    drive(8, 8'h01, 8'h00, 5'b01100, "R11");
    drive(3, 8'h80, 8'h80, 5'b01001, "R11");
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 0, "R1", "idle out_valid", out_valid, 0);
    check(flags_out == last.f && flags_wr == last.m, "R1", "idle hold", flags_out, last.f);
    check(q.size() == 0, "R1", "pending items", q.size(), 0);
    finish_run();
  end
endmodule